// File: doc/BRIEF.md
# Coalesced Probe Issue Scheduler

This block sits between a request coalescer and the next translation level. Requests that share a virtual page and an access kind are grouped upstream into bundles. Bundles are grouped by arrival time window. The block holds those bundles and decides each cycle which of them go down as probes. Each bundle goes down as one probe on one of several parallel lanes.

Windows are kept in age order in a small ring. The scan starts at the oldest window and takes bundles in arrival order. Inside a window, a bundle may overtake an older one that is stuck. A bundle is stuck when its page already has a probe in flight, or when the in-flight table has no free entry. Once any bundle is stuck, the scan finishes that window but does not open a younger one.

When the lanes are taken, each issued bundle leaves the pending store. Its page is then recorded as in flight until a completion names that page. When the lower level turns probes away, nothing leaves the store. The scheduler then goes quiet until the lower level is ready again, and scans afresh on the following cycle.

Top module: `probe_issue_sched`

## Requirements
- R1: After reset no lane is valid and `push_ready` is high.
- R2: No more than PROBES lanes are valid in a cycle. Valid lanes are packed from lane 0 upward, and the scan stops as soon as the last lane is filled.
- R3: Lane 0 carries the first eligible bundle, taken from the oldest window first and in push order within a window. Each lane carries the pushed page, the access kind bit and the member count unchanged.
- R4: A bundle is not offered when its page is already in flight or is already on a lower lane in the same cycle. Later bundles of the same window may still be offered, but no bundle from a younger window is offered in that cycle.
- R5: A bundle is treated as in R4 when the in-flight table has no free entry left for it.
- R6: When any lane is valid while `lo_ready` is low, no bundle leaves the store. No lane is valid from the next cycle on until the cycle after `lo_ready` is seen high; the scan then runs again.
- R7: When lanes are offered with `lo_ready` high, every offered bundle is removed and its page becomes in flight.
- R8: A window is freed once all of its bundles have been issued. At most NUM_WIN windows are held.
- R9: A completion (`done_valid` with `done_page`) frees that in-flight page, so a bundle for it may be offered from the next cycle.
- R10: A push is appended to the newest window when `push_new_win` is low and that window has a free slot. Otherwise the push opens a new window if one is free. `push_ready` shows whether the push can be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | A bundle is presented for storing |
| push_new_win | input | 1 | Start a new time window with this bundle |
| push_page | input | PG_W | Virtual page of the bundle |
| push_wr | input | 1 | Access kind (1 = write) |
| push_members | input | MEM_W | Number of requests merged in the bundle |
| push_ready | output | 1 | The presented bundle would be stored |
| lo_valid | output | PROBES | Per-lane probe valid |
| lo_page | output | PROBES*PG_W | Per-lane page, lane k at bits k*PG_W |
| lo_wr | output | PROBES | Per-lane access kind |
| lo_members | output | PROBES*MEM_W | Per-lane member count |
| lo_ready | input | 1 | Lower level takes all offered lanes |
| done_valid | input | 1 | A translation for a page completed |
| done_page | input | PG_W | Page whose in-flight entry is freed |

## Verification
A wrong window head or a stale slot bit shows up on the lanes in the very next scan. It appears as a bundle offered out of age order, a bundle offered twice, or a younger window leaking past a stuck one. An in-flight entry that is lost or kept too long shows up as a duplicate page on a lane, or as a bundle held back after its completion. Both are visible within one cycle of the fault. The bench keeps its own model of windows, bundles and in-flight pages and compares every lane and `push_ready` on every cycle. So any divergence is reported in the cycle where it first reaches the ports.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

    localparam int PG_W  = 12;
    localparam int MEM_W = 4;

    typedef struct packed {
        logic [PG_W-1:0]  page;
        logic             wr;
        logic [MEM_W-1:0] members;
    } bundle_t;

    function automatic int ring_add(int base, int off, int n);
        return (base + off) % n;
    endfunction

endpackage

// File: rtl/pq_store.sv
module pq_store
    import pscan_pkg::*;
#(
    parameter int NW = 4,
    parameter int NS = 4,
    parameter int P  = 2,
    localparam int WIW = $clog2(NW),
    localparam int SIW = $clog2(NS),
    localparam int CW  = $clog2(NW + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push_valid,
    input  logic                     push_new_win,
    input  bundle_t                  push_data,
    output logic                     push_ready,
    input  logic                     take,
    input  logic [P-1:0]             sel_valid,
    input  logic [WIW-1:0]           sel_win [P],
    input  logic [SIW-1:0]           sel_slot [P],
    input  logic [CW-1:0]            free_lead,
    output logic [NW-1:0][NS-1:0]    live,
    output bundle_t                  data [NW][NS],
    output logic [WIW-1:0]           head,
    output logic [CW-1:0]            wcount
);

    logic [SIW:0]   fill [NW];
    logic [WIW-1:0] tail;
    logic [WIW-1:0] nxt;
    logic           can_append;
    logic           can_open;
    logic           do_append;
    logic           do_open;
    logic [CW-1:0]  eff_free;

    always_comb begin
        tail       = WIW'(ring_add(int'(head), int'(wcount) + NW - 1, NW));
        nxt        = WIW'(ring_add(int'(head), int'(wcount), NW));
        can_append = (wcount != '0) && !push_new_win && (int'(fill[tail]) < NS);
        can_open   = int'(wcount) < NW;
        push_ready = can_append || can_open;
        do_append  = push_valid && can_append;
        do_open    = push_valid && !can_append && can_open;
        eff_free   = take ? free_lead : '0;
        // the newest window survives when it receives a bundle this cycle
        if (do_append && (eff_free == wcount)) eff_free = eff_free - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live   <= '0;
            head   <= '0;
            wcount <= '0;
            for (int w = 0; w < NW; w++) fill[w] <= '0;
        end else begin
            if (take) begin
                for (int k = 0; k < P; k++)
                    if (sel_valid[k]) live[sel_win[k]][sel_slot[k]] <= 1'b0;
            end
            for (int k = 0; k < NW; k++)
                if (k < int'(eff_free)) fill[ring_add(int'(head), k, NW)] <= '0;
            head <= WIW'(ring_add(int'(head), int'(eff_free), NW));
            if (do_append) begin
                live[tail][SIW'(fill[tail])] <= 1'b1;
                data[tail][SIW'(fill[tail])] <= push_data;
                fill[tail]                   <= fill[tail] + 1'b1;
            end
            if (do_open) begin
                live[nxt][0] <= 1'b1;
                data[nxt][0] <= push_data;
                fill[nxt]    <= (SIW+1)'(1);
            end
            wcount <= wcount - eff_free + CW'(do_open);
        end
    end

    // R8: the ring never holds more windows than it has
    a_r8_window_bound: assert property (@(posedge clk) disable iff (rst)
        wcount <= CW'(NW));

    // R6: without a taken offer the oldest window does not move
    a_r6_head_hold: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(head));

    // R10: a stored push leaves at least one window in the ring
    a_r10_push_lands: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_ready) |=> (wcount != '0));

endmodule

// File: rtl/pq_pick.sv
module pq_pick
    import pscan_pkg::*;
#(
    parameter int NW = 4,
    parameter int NS = 4,
    parameter int P  = 2,
    parameter int ND = 4,
    localparam int WIW = $clog2(NW),
    localparam int SIW = $clog2(NS),
    localparam int CW  = $clog2(NW + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hold,
    input  logic [NW-1:0][NS-1:0] live,
    input  bundle_t               data [NW][NS],
    input  logic [WIW-1:0]        head,
    input  logic [CW-1:0]         wcount,
    input  logic [ND-1:0]         out_live,
    input  logic [PG_W-1:0]       out_page [ND],
    output logic [P-1:0]          sel_valid,
    output logic [WIW-1:0]        sel_win [P],
    output logic [SIW-1:0]        sel_slot [P],
    output bundle_t               sel_data [P],
    output logic [CW-1:0]         free_lead
);

    logic [PG_W-1:0] picked [P];
    int              sent;
    int              nfree;
    int              lead;
    int              w;
    logic            blocked;
    logic            stop;
    logic            run;
    logic            left;
    logic            hit;

    always_comb begin
        sel_valid = '0;
        for (int k = 0; k < P; k++) begin
            sel_win[k]  = '0;
            sel_slot[k] = '0;
            sel_data[k] = '0;
            picked[k]   = '0;
        end
        nfree = 0;
        for (int e = 0; e < ND; e++)
            if (!out_live[e]) nfree = nfree + 1;
        sent    = 0;
        lead    = 0;
        blocked = 1'b0;
        stop    = 1'b0;
        run     = 1'b1;
        left    = 1'b0;
        hit     = 1'b0;
        w       = 0;
        for (int k = 0; k < NW; k++) begin
            w = ring_add(int'(head), k, NW);
            if (!hold && (k < int'(wcount)) && !blocked && !stop) begin
                left = 1'b0;
                for (int s = 0; s < NS; s++) begin
                    if (live[w][s]) begin
                        hit = 1'b0;
                        for (int e = 0; e < ND; e++)
                            if (out_live[e] && (out_page[e] == data[w][s].page)) hit = 1'b1;
                        for (int j = 0; j < P; j++)
                            if ((j < sent) && (picked[j] == data[w][s].page)) hit = 1'b1;
                        if (sent >= P) begin
                            stop = 1'b1;
                            left = 1'b1;
                        end else if (hit || (sent >= nfree)) begin
                            blocked = 1'b1;
                            left    = 1'b1;
                        end else begin
                            for (int j = 0; j < P; j++) begin
                                if (j == sent) begin
                                    sel_valid[j] = 1'b1;
                                    sel_win[j]   = WIW'(w);
                                    sel_slot[j]  = SIW'(s);
                                    sel_data[j]  = data[w][s];
                                    picked[j]    = data[w][s].page;
                                end
                            end
                            sent = sent + 1;
                        end
                    end
                end
                if (run && !left) lead = lead + 1;
                else run = 1'b0;
            end else begin
                run = 1'b0;
            end
        end
        free_lead = CW'(lead);
    end

    // R6: a held scheduler offers nothing
    a_r6_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        hold |-> (sel_valid == '0));

    for (genvar k = 1; k < P; k++) begin : g_pack
        // R2: lanes fill from lane 0 upward
        a_r2_lane_packed: assert property (@(posedge clk) disable iff (rst)
            sel_valid[k] |-> sel_valid[k-1]);
    end

    for (genvar k = 0; k < P; k++) begin : g_lane
        for (genvar e = 0; e < ND; e++) begin : g_ent
            // R4: an in-flight page is never offered again
            a_r4_no_inflight_page: assert property (@(posedge clk) disable iff (rst)
                (sel_valid[k] && out_live[e]) |-> (sel_data[k].page != out_page[e]));
        end
    end

endmodule

// File: rtl/pq_track.sv
module pq_track
    import pscan_pkg::*;
#(
    parameter int ND = 4,
    parameter int P  = 2,
    localparam int EIW = $clog2(ND)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic [P-1:0]    lane_valid,
    input  logic [PG_W-1:0] lane_page [P],
    input  logic            rel_valid,
    input  logic [PG_W-1:0] rel_page,
    output logic [ND-1:0]   out_live,
    output logic [PG_W-1:0] out_page [ND]
);

    logic [EIW-1:0] slot_of [P];
    int             nth;

    always_comb begin
        nth = 0;
        for (int k = 0; k < P; k++) slot_of[k] = '0;
        for (int e = 0; e < ND; e++) begin
            if (!out_live[e]) begin
                for (int k = 0; k < P; k++)
                    if (k == nth) slot_of[k] = EIW'(e);
                nth = nth + 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_live <= '0;
        end else begin
            if (rel_valid) begin
                for (int e = 0; e < ND; e++)
                    if (out_live[e] && (out_page[e] == rel_page)) out_live[e] <= 1'b0;
            end
            if (take) begin
                for (int k = 0; k < P; k++) begin
                    if (lane_valid[k]) begin
                        out_live[slot_of[k]] <= 1'b1;
                        out_page[slot_of[k]] <= lane_page[k];
                    end
                end
            end
        end
    end

    for (genvar e = 0; e < ND; e++) begin : g_e
        // R9: a completion frees the matching entry
        a_r9_release_frees: assert property (@(posedge clk) disable iff (rst)
            (rel_valid && out_live[e] && (out_page[e] == rel_page)) |=> !out_live[e]);
        for (genvar f = e + 1; f < ND; f++) begin : g_f
            // R7: one in-flight entry per page
            a_r7_unique_page: assert property (@(posedge clk) disable iff (rst)
                (out_live[e] && out_live[f]) |-> (out_page[e] != out_page[f]));
        end
    end

endmodule

// File: rtl/probe_issue_sched.sv
module probe_issue_sched
    import pscan_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int WIN_SLOTS = 4,
    parameter int PROBES    = 2,
    parameter int OUT_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push_valid,
    input  logic                      push_new_win,
    input  logic [PG_W-1:0]           push_page,
    input  logic                      push_wr,
    input  logic [MEM_W-1:0]          push_members,
    output logic                      push_ready,
    output logic [PROBES-1:0]         lo_valid,
    output logic [PROBES*PG_W-1:0]    lo_page,
    output logic [PROBES-1:0]         lo_wr,
    output logic [PROBES*MEM_W-1:0]   lo_members,
    input  logic                      lo_ready,
    input  logic                      done_valid,
    input  logic [PG_W-1:0]           done_page
);

    localparam int WIW = $clog2(NUM_WIN);
    localparam int SIW = $clog2(WIN_SLOTS);
    localparam int CW  = $clog2(NUM_WIN + 1);

    bundle_t                         push_data;
    logic [NUM_WIN-1:0][WIN_SLOTS-1:0] live;
    bundle_t                         data [NUM_WIN][WIN_SLOTS];
    logic [WIW-1:0]                  head;
    logic [CW-1:0]                   wcount;
    logic [PROBES-1:0]               sel_valid;
    logic [WIW-1:0]                  sel_win [PROBES];
    logic [SIW-1:0]                  sel_slot [PROBES];
    bundle_t                         sel_data [PROBES];
    logic [PG_W-1:0]                 lane_page [PROBES];
    logic [CW-1:0]                   free_lead;
    logic [OUT_DEPTH-1:0]            out_live;
    logic [PG_W-1:0]                 out_page [OUT_DEPTH];
    logic                            waiting;
    logic                            offer;
    logic                            take;

    assign push_data = '{page: push_page, wr: push_wr, members: push_members};
    assign offer     = |sel_valid;
    assign take      = offer && lo_ready;
    assign lo_valid  = sel_valid;

    for (genvar k = 0; k < PROBES; k++) begin : g_lane
        assign lo_page[k*PG_W +: PG_W]       = sel_data[k].page;
        assign lo_wr[k]                      = sel_data[k].wr;
        assign lo_members[k*MEM_W +: MEM_W]  = sel_data[k].members;
        assign lane_page[k]                  = sel_data[k].page;
    end

    // refused offers park the scheduler until the lower level is ready again
    always_ff @(posedge clk) begin
        if (rst)                       waiting <= 1'b0;
        else if (offer && !lo_ready)   waiting <= 1'b1;
        else if (waiting && lo_ready)  waiting <= 1'b0;
    end

    pq_store #(.NW(NUM_WIN), .NS(WIN_SLOTS), .P(PROBES)) store_i (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_new_win(push_new_win),
        .push_data(push_data), .push_ready(push_ready),
        .take(take), .sel_valid(sel_valid), .sel_win(sel_win),
        .sel_slot(sel_slot), .free_lead(free_lead),
        .live(live), .data(data), .head(head), .wcount(wcount)
    );

    pq_pick #(.NW(NUM_WIN), .NS(WIN_SLOTS), .P(PROBES), .ND(OUT_DEPTH)) pick_i (
        .clk(clk), .rst(rst), .hold(waiting),
        .live(live), .data(data), .head(head), .wcount(wcount),
        .out_live(out_live), .out_page(out_page),
        .sel_valid(sel_valid), .sel_win(sel_win), .sel_slot(sel_slot),
        .sel_data(sel_data), .free_lead(free_lead)
    );

    pq_track #(.ND(OUT_DEPTH), .P(PROBES)) track_i (
        .clk(clk), .rst(rst), .take(take),
        .lane_valid(sel_valid), .lane_page(lane_page),
        .rel_valid(done_valid), .rel_page(done_page),
        .out_live(out_live), .out_page(out_page)
    );

    // R6: a refused offer is followed by a quiet cycle
    a_r6_refuse_quiet: assert property (@(posedge clk) disable iff (rst)
        (offer && !lo_ready) |=> (lo_valid == '0));

    // R6: a refused offer leaves the window ring where it was
    a_r6_refuse_keeps: assert property (@(posedge clk) disable iff (rst)
        (offer && !lo_ready) |=> ($stable(head) && ($countones(live) >= $countones($past(live)))));

endmodule

// File: tb/probe_issue_sched_tb_top.sv
module probe_issue_sched_tb_top;
    import pscan_pkg::*;

    localparam int NW = 4;
    localparam int NS = 4;
    localparam int P  = 2;
    localparam int ND = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic push_valid = 1'b0, push_new_win = 1'b0, push_wr = 1'b0;
    logic [PG_W-1:0]  push_page = '0;
    logic [MEM_W-1:0] push_members = '0;
    logic push_ready;
    logic [P-1:0] lo_valid, lo_wr;
    logic [P*PG_W-1:0] lo_page;
    logic [P*MEM_W-1:0] lo_members;
    logic lo_ready = 1'b0;
    logic done_valid = 1'b0;
    logic [PG_W-1:0] done_page = '0;

    always #2 clk = ~clk;

    probe_issue_sched #(.NUM_WIN(NW), .WIN_SLOTS(NS), .PROBES(P), .OUT_DEPTH(ND)) dut_i (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_new_win(push_new_win),
        .push_page(push_page), .push_wr(push_wr), .push_members(push_members),
        .push_ready(push_ready), .lo_valid(lo_valid), .lo_page(lo_page), .lo_wr(lo_wr),
        .lo_members(lo_members), .lo_ready(lo_ready), .done_valid(done_valid),
        .done_page(done_page)
    );

    typedef struct packed { int wid; int page; logic wr; int mem; } mb_t;
    mb_t bq[$];
    int  wins[$];
    int  fillc[int];
    int  outs[$];
    int  exp_idx[$];
    bit  m_wait;
    int  next_wid;
    int  n_checks = 0;
    int  n_fail = 0;

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
        end
    endtask

    function automatic bit in_outs(int pg);
        foreach (outs[i]) if (outs[i] == pg) return 1;
        return 0;
    endfunction

    function automatic void compute_expect();
        int sent = 0;
        bit blocked = 0;
        bit stop = 0;
        exp_idx.delete();
        if (m_wait) return;
        foreach (wins[wi]) begin
            if (blocked || stop) break;
            foreach (bq[bi]) begin
                if (bq[bi].wid == wins[wi]) begin
                    bit dup = in_outs(bq[bi].page);
                    foreach (exp_idx[j]) if (bq[exp_idx[j]].page == bq[bi].page) dup = 1;
                    if (sent >= P) stop = 1;
                    else if (dup || (outs.size() + sent >= ND)) blocked = 1;
                    else begin
                        exp_idx.push_back(bi);
                        sent++;
                    end
                end
            end
        end
    endfunction

    task automatic compare_lanes(string tag);
        compute_expect();
        for (int k = 0; k < P; k++) begin
            bit ev = (k < exp_idx.size());
            check(lo_valid[k] == ev, tag, $sformatf("lane%0d valid", k), int'(lo_valid[k]), int'(ev));
            if (ev && lo_valid[k]) begin
                mb_t b = bq[exp_idx[k]];
                check(int'(lo_page[k*PG_W +: PG_W]) == b.page, tag, $sformatf("lane%0d page", k),
                      int'(lo_page[k*PG_W +: PG_W]), b.page);
                check(lo_wr[k] == b.wr, tag, $sformatf("lane%0d kind", k), int'(lo_wr[k]), int'(b.wr));
                check(int'(lo_members[k*MEM_W +: MEM_W]) == b.mem, tag, $sformatf("lane%0d members", k),
                      int'(lo_members[k*MEM_W +: MEM_W]), b.mem);
            end
        end
    endtask

    function automatic bit win_empty(int id);
        foreach (bq[i]) if (bq[i].wid == id) return 0;
        return 1;
    endfunction

    task automatic model_step();
        bit offer = exp_idx.size() > 0;
        bit take = offer && lo_ready;
        bit can_app = (wins.size() > 0) && !push_new_win && (fillc[wins[$]] < NS);
        bit can_open = wins.size() < NW;
        if (done_valid) begin
            for (int i = outs.size() - 1; i >= 0; i--)
                if (outs[i] == int'(done_page)) outs.delete(i);
        end
        if (take) begin
            foreach (exp_idx[j]) outs.push_back(bq[exp_idx[j]].page);
            for (int j = exp_idx.size() - 1; j >= 0; j--) bq.delete(exp_idx[j]);
        end
        if (push_valid && (can_app || can_open)) begin
            mb_t b;
            b.page = int'(push_page);
            b.wr = push_wr;
            b.mem = int'(push_members);
            if (can_app) begin
                b.wid = wins[$];
                fillc[wins[$]] = fillc[wins[$]] + 1;
            end else begin
                b.wid = next_wid;
                wins.push_back(next_wid);
                fillc[next_wid] = 1;
                next_wid++;
            end
            bq.push_back(b);
        end
        while ((wins.size() > 0) && win_empty(wins[0])) void'(wins.pop_front());
        if (offer && !lo_ready) m_wait = 1;
        else if (m_wait && lo_ready) m_wait = 0;
    endtask

    task automatic run_phase(string tag, int n, int pp, int pnw, int prange, int prdy, int prel);
        repeat (n) begin
            @(negedge clk);
            compare_lanes(tag);
            push_valid   = ($urandom % 100) < pp;
            push_new_win = ($urandom % 100) < pnw;
            push_page    = PG_W'($urandom % prange);
            push_wr      = 1'($urandom % 2);
            push_members = MEM_W'(1 + $urandom % 15);
            lo_ready     = ($urandom % 100) < prdy;
            done_valid   = ($urandom % 100) < prel;
            if (outs.size() > 0 && ($urandom % 4) != 0) done_page = PG_W'(outs[$urandom % outs.size()]);
            else done_page = PG_W'($urandom % prange);
            #1;
            begin
                bit er = ((wins.size() > 0) && !push_new_win && (fillc[wins[$]] < NS)) || (wins.size() < NW);
                check(push_ready == er, (tag == "R8") ? "R8" : "R10", "push_ready", int'(push_ready), int'(er));
            end
            model_step();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        m_wait = 0;
        next_wid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check(lo_valid == '0, "R1", "lo_valid after reset", int'(lo_valid), 0);
        check(push_ready == 1'b1, "R1", "push_ready after reset", int'(push_ready), 1);
        run_phase("R10", 12, 100, 0, 16, 0, 0);
        run_phase("R3", 400, 50, 40, 64, 100, 60);
        run_phase("R2", 400, 100, 10, 256, 100, 100);
        run_phase("R4", 400, 70, 30, 4, 90, 30);
        run_phase("R5", 300, 80, 20, 256, 100, 5);
        run_phase("R6", 400, 60, 30, 32, 35, 50);
        run_phase("R7", 400, 60, 30, 16, 80, 40);
        run_phase("R8", 300, 90, 70, 128, 20, 30);
        run_phase("R9", 400, 40, 30, 8, 90, 70);
        run_phase("R7", 100, 0, 0, 16, 100, 100);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule